// File: doc/BRIEF.md
# Latched Multiplexer Switch Controller

This block drives the on/off controls of a sixteen-way analog switch array from a small parallel control port. A channel address and an enable bit pass through level-style holding registers. They follow their inputs while the write strobe is low and freeze when the strobe goes high. An active-low clear empties them and opens every switch. The controller turns the held values into a one-hot set of sixteen switch controls.

The switch controls never go straight from one channel to another. When the selected channel changes, every control goes low for a programmable number of clock cycles before the new one is driven, so two sources are never joined. A mode pin regroups the array as eight differential pairs. The low three address bits then pick a pair, and both halves of that pair are driven together. All control pins are taken as already synchronous to the single clock.

Top module: `mux_switch_ctrl`

## Requirements
- R1: While `wrN` is low, the held address and enable follow `addrIn` and `enIn`. A change there reaches `swOn` two clock edges after it is applied, provided no break gap is needed.
- R2: While `wrN` is high, the held address and enable keep the last values taken while it was low. Changes on `addrIn` and `enIn` have no effect on `swOn`.
- R3: While `clrN` is low, every `swOn` bit is 0 from the first edge on, and the held address and enable are cleared to 0 even if `wrN` is low. After `clrN` is released with `wrN` high, `swOn` stays 0.
- R4: In single-ended mode (`diffMode`=0), a held enable of 0 gives `swOn`=0. A held enable of 1 with address n gives exactly bit n of `swOn` set, so address 0 drives bit 0 and address 15 drives bit 15.
- R5: In differential mode (`diffMode`=1), address bit 3 is ignored. Low address bits k drive bit k (side A) and bit k+8 (side B) of `swOn`, and no other bit.
- R6: When a driven channel is replaced by a different one, `swOn` is 0 for exactly BBM_CYCLES cycles (default 2) before the new channel is driven. Re-selecting the same channel, or the same pair in differential mode, causes no gap.
- R7: If the target changes again while a gap is running, the gap starts over. Only the newest target is ever driven.
- R8: A held enable of 0 clears `swOn` one edge after it is held, with no gap. Enabling from the all-off state drives the channel with no gap.
- R9: At every cycle, `swOn` has at most one bit set in single-ended mode and at most two bits set in differential mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clrN | input | 1 | Active-low clear of the holding registers and the switch state |
| addrIn | input | 4 | Channel address |
| enIn | input | 1 | Channel enable, active high |
| wrN | input | 1 | Write strobe, active low; holding registers are open while low |
| diffMode | input | 1 | 1 selects eight differential pairs; keep it steady while a channel is on |
| swOn | output | 16 | Switch-on controls, one bit per switch |

## Verification
An input change is taken into the holding registers at the first edge and acts on the switch state at the second edge. The bench therefore drives on falling edges and samples `swOn` after each rising edge. A turn-on from all-off or a turn-off is expected after two edges. A channel-to-channel move shows zeros after edges two through BBM_CYCLES+1 and the new channel one edge later. A restarted gap adds BBM_CYCLES more zero cycles, counted from the edge at which the newest address is seen. Every ordered pair of addresses is swept in both modes and checked at each of these cycles. The at-most-one-channel rule is checked at every sample.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {ST_OFF = 2'd0, ST_ON = 2'd1, ST_GAP = 2'd2} swc_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic chanLoad;  // copy the current target into the channel register
    logic drive;     // drive the decoded channel onto the switch controls
  } swc_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic tgtEn;       // held enable
    logic tgtDiffers;  // held target differs from the channel register
  } swc_status_t;
endpackage

// File: rtl/swc_datapath.sv
module swc_datapath
  import swc_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int PAIRS = NUM_CH / 2
) (
  input  logic              clk,
  input  logic              clrN,
  input  logic [CH_W-1:0]   addrIn,
  input  logic              enIn,
  input  logic              wrN,
  input  logic              diffMode,
  input  swc_strobe_t       strobe,
  output swc_status_t       status,
  output logic [NUM_CH-1:0] swOn
);
  logic [CH_W-1:0] latAddr;
  logic            latEn;
  logic [CH_W-1:0] chanReg;
  logic [CH_W-1:0] tgtCh;

  // holding registers: open while the strobe is low, clear wins
  always_ff @(posedge clk) begin
    if (!clrN) begin
      latAddr <= '0;
      latEn   <= 1'b0;
    end else if (!wrN) begin
      latAddr <= addrIn;
      latEn   <= enIn;
    end
  end

  // in differential mode the top address bit is dropped
  always_comb begin
    tgtCh = latAddr;
    if (diffMode) tgtCh[CH_W-1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!clrN) chanReg <= '0;
    else if (strobe.chanLoad) chanReg <= tgtCh;
  end

  assign status.tgtEn      = latEn;
  assign status.tgtDiffers = (tgtCh != chanReg);

  // decode: one switch per bit, or a pair (k, k+PAIRS) in differential mode
  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    localparam int PAIR_IDX = i % PAIRS;
    assign swOn[i] = strobe.drive &&
                     (diffMode ? (chanReg[CH_W-2:0] == (CH_W-1)'(PAIR_IDX))
                               : (chanReg == CH_W'(i)));
  end

  // R2: with the strobe high the held values do not move
  p_hold_r2: assert property (@(posedge clk) disable iff (!clrN)
    wrN |=> ($stable(latAddr) && $stable(latEn)));

  // R3: first cycle after clear release sees empty holding registers
  p_clear_r3: assert property (@(posedge clk) disable iff (!clrN)
    $rose(clrN) |-> (!latEn && latAddr == '0));
endmodule

// File: rtl/swc_ctrl.sv
module swc_ctrl
  import swc_pkg::*;
#(
  parameter int BBM_CYCLES = 2,
  localparam int CNT_W = $clog2(BBM_CYCLES + 1)
) (
  input  logic        clk,
  input  logic        clrN,
  input  swc_status_t status,
  output swc_strobe_t strobe
);
  swc_state_e state, stateNxt;
  logic [CNT_W-1:0] gapCnt, gapCntNxt;

  always_comb begin
    stateNxt        = state;
    gapCntNxt       = gapCnt;
    strobe.chanLoad = 1'b0;
    unique case (state)
      ST_OFF: if (status.tgtEn) begin
        strobe.chanLoad = 1'b1;
        stateNxt        = ST_ON;
      end
      ST_ON: if (!status.tgtEn) begin
        stateNxt = ST_OFF;
      end else if (status.tgtDiffers) begin
        strobe.chanLoad = 1'b1;
        gapCntNxt       = CNT_W'(BBM_CYCLES - 1);
        stateNxt        = ST_GAP;
      end
      ST_GAP: if (!status.tgtEn) begin
        stateNxt = ST_OFF;
      end else if (status.tgtDiffers) begin
        strobe.chanLoad = 1'b1;
        gapCntNxt       = CNT_W'(BBM_CYCLES - 1);
      end else if (gapCnt == '0) begin
        stateNxt = ST_ON;
      end else begin
        gapCntNxt = gapCnt - 1'b1;
      end
      default: stateNxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!clrN) begin
      state  <= ST_OFF;
      gapCnt <= '0;
    end else begin
      state  <= stateNxt;
      gapCnt <= gapCntNxt;
    end
  end

  assign strobe.drive = (state == ST_ON);

  // R6: leaving a driven channel for another always enters an undriven gap
  p_gap_entry_r6: assert property (@(posedge clk) disable iff (!clrN)
    (strobe.drive && strobe.chanLoad) |=> !strobe.drive);

  // R7: the gap counter stays within its window
  p_gap_bound_r7: assert property (@(posedge clk) disable iff (!clrN)
    (state == ST_GAP) |-> (gapCnt < CNT_W'(BBM_CYCLES)));
endmodule

// File: rtl/mux_switch_ctrl.sv
module mux_switch_ctrl
  import swc_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int BBM_CYCLES = 2,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              clrN,
  input  logic [CH_W-1:0]   addrIn,
  input  logic              enIn,
  input  logic              wrN,
  input  logic              diffMode,
  output logic [NUM_CH-1:0] swOn
);
  swc_strobe_t strobe;
  swc_status_t status;

  swc_datapath #(.NUM_CH(NUM_CH)) datapath_i (
    .clk(clk), .clrN(clrN), .addrIn(addrIn), .enIn(enIn), .wrN(wrN),
    .diffMode(diffMode), .strobe(strobe), .status(status), .swOn(swOn)
  );

  swc_ctrl #(.BBM_CYCLES(BBM_CYCLES)) ctrl_i (
    .clk(clk), .clrN(clrN), .status(status), .strobe(strobe)
  );

  // R9: never more than one channel (or one pair) on
  p_onehot_r9: assert property (@(posedge clk) disable iff (!clrN)
    $countones(swOn) <= (diffMode ? 2 : 1));

  // R6: a driven pattern never turns straight into a different driven pattern
  p_no_jump_r6: assert property (@(posedge clk) disable iff (!clrN)
    ((swOn != '0) && ($past(swOn) != '0)) |-> (swOn == $past(swOn)));

  // R8: a cleared held enable drops every control one edge later
  p_off_r8: assert property (@(posedge clk) disable iff (!clrN)
    !status.tgtEn |=> (swOn == '0));
endmodule

// File: tb/mux_switch_ctrl_tb_top.sv
module mux_switch_ctrl_tb_top;
  localparam int BBM = 2;

  logic        clk = 1'b0;
  logic        clrN = 1'b0;
  logic [3:0]  addrIn = '0;
  logic        enIn = 1'b0;
  logic        wrN = 1'b1;
  logic        diffMode = 1'b0;
  logic [15:0] swOn;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  mux_switch_ctrl #(.NUM_CH(16), .BBM_CYCLES(BBM)) dut_i (
    .clk(clk), .clrN(clrN), .addrIn(addrIn), .enIn(enIn), .wrN(wrN),
    .diffMode(diffMode), .swOn(swOn)
  );

  function automatic logic [15:0] expOf(input logic [3:0] a, input logic dm);
    if (dm) return (16'd1 << (a % 8)) | (16'd1 << ((a % 8) + 8));
    return 16'd1 << a;
  endfunction

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string req);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: swOn=%h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // R9 checked at every sample point
  always @(negedge clk) begin
    if (clrN && !done) begin
      nChecks++;
      if ($countones(swOn) > (diffMode ? 2 : 1)) begin
        nFails++;
        $display("FAIL R9: swOn=%h has %0d bits set", swOn, $countones(swOn));
      end
    end
  end

  task automatic settle(input logic [3:0] a);
    addrIn = a; enIn = 1'b1; wrN = 1'b0;
    for (int i = 0; i < BBM + 4; i++) tick();
  endtask

  // move from the current channel to b and check every cycle (R1, R6)
  task automatic moveTo(input logic [3:0] a, input logic [3:0] b);
    logic [15:0] oldV, newV;
    bit same;
    oldV = expOf(a, diffMode);
    newV = expOf(b, diffMode);
    same = (oldV == newV);
    addrIn = b;
    tick();
    check(swOn, oldV, "R1 latch edge only");
    for (int i = 0; i < BBM; i++) begin
      tick();
      check(swOn, same ? oldV : 16'd0, same ? "R6 no gap same target" : "R6 gap");
    end
    tick();
    check(swOn, newV, diffMode ? "R5 new pair" : "R6 new channel");
  endtask

  initial begin
    repeat (3) tick();
    check(swOn, 16'd0, "R3 reset state");
    clrN = 1'b1;
    tick();

    // R4: every address from all-off, plus enable 0
    for (int a = 0; a < 16; a++) begin
      addrIn = 4'(a); enIn = 1'b0; wrN = 1'b0;
      tick(); tick();
      check(swOn, 16'd0, "R4 enable low");
      enIn = 1'b1;
      tick();
      check(swOn, 16'd0, "R8 first edge");
      tick();
      check(swOn, expOf(4'(a), 1'b0), "R4 decode / R8 no gap on");
    end

    // R6: all ordered pairs, single-ended
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        settle(4'(a));
        check(swOn, expOf(4'(a), 1'b0), "R4 settled");
        moveTo(4'(a), 4'(b));
      end

    // R2: strobe high freezes
    settle(4'd5);
    wrN = 1'b1; addrIn = 4'd12; enIn = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      check(swOn, expOf(4'd5, 1'b0), "R2 hold");
    end
    wrN = 1'b0;
    tick(); tick();
    check(swOn, 16'd0, "R1 follow after release / R8 off no gap");

    // R7: restart of a gap
    settle(4'd3);
    addrIn = 4'd5;
    tick(); tick();
    check(swOn, 16'd0, "R7 gap begins");
    addrIn = 4'd9;
    for (int i = 0; i < BBM + 1; i++) begin
      tick();
      check(swOn, 16'd0, "R7 gap restarted");
    end
    tick();
    check(swOn, expOf(4'd9, 1'b0), "R7 newest target");

    // R8: enable off then on to another channel
    settle(4'd6);
    enIn = 1'b0;
    tick();
    check(swOn, expOf(4'd6, 1'b0), "R8 off first edge");
    tick();
    check(swOn, 16'd0, "R8 off no gap");
    addrIn = 4'd11; enIn = 1'b1;
    tick(); tick();
    check(swOn, expOf(4'd11, 1'b0), "R8 on no gap");

    // R3: clear with strobe low, then release with strobe high
    clrN = 1'b0;
    tick();
    check(swOn, 16'd0, "R3 clear drops outputs");
    tick();
    check(swOn, 16'd0, "R3 clear wins over strobe");
    wrN = 1'b1;
    tick();
    clrN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      check(swOn, 16'd0, "R3 held cleared after release");
    end
    wrN = 1'b0;
    tick(); tick();
    check(swOn, expOf(4'd11, 1'b0), "R3 reopen");

    // R5: differential mode, every ordered pair
    clrN = 1'b0; tick(); tick();
    diffMode = 1'b1; clrN = 1'b1; tick();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        settle(4'(a));
        check(swOn, expOf(4'(a), 1'b1), "R5 pair decode");
        moveTo(4'(a), 4'(b));
      end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1'b1;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule